// File: doc/BRIEF.md
# Circular Receive Memory Drainer

This block empties received bytes out of a peripheral's circular receive memory. It reaches that memory only through a byte-wide register port. A request carries a largest acceptable byte count. The drainer first reads two 16-bit status registers over the port: the number of bytes waiting, then the ring read pointer. It then settles on how many bytes to take.

Each byte is fetched from its physical location, which is the ring base plus the masked pointer. When the run would pass the top of the ring, the fetch is split into two address runs, and the second run restarts at the base. Every fetched byte is offered on a valid/ready stream before the next fetch is issued. Once the last byte has been accepted, the block writes the advanced pointer back, issues the receive-acknowledge command, and reports how many bytes it moved.

The register port is a simple request/acknowledge channel. The block holds a request until the peripheral returns a one-cycle acknowledge, which carries read data for reads. The following are all parameters:
- the ring base
- the ring mask
- the local buffer limit
- the three register addresses
- the command code

Top module: `rx_ring_drainer`

## Requirements
- R1: After reset `busy_o`, `done_o`, `bus_req_o` and `byte_valid_o` are 0 and `count_o` is 0.
- R2: On `start_i` the block reads the waiting-size register as a high byte at `SIZE_ADDR` followed by a low byte at `SIZE_ADDR+1`. When the size is nonzero, it then reads the read pointer the same way at `PTR_ADDR` and `PTR_ADDR+1`.
- R3: The transfer count is the smallest of `max_len_i`, `BUF_LEN` and the waiting size. It appears on `count_o` in the cycle `done_o` is high.
- R4: A waiting size of zero ends the request with a count of 0, and no bus access follows the size read.
- R5: Data bytes are read starting at `RING_BASE + (pointer & RING_MASK)` at ascending addresses.
- R6: When offset plus count exceeds `RING_MASK+1`, the first `RING_MASK+1-offset` bytes come from the start address and the rest from `RING_BASE` upward. When offset plus count equals `RING_MASK+1`, no read touches `RING_BASE`.
- R7: Bytes leave on `byte_data_o` in the order read. While `byte_valid_o` is high and `byte_ready_i` is low, the byte is held and no bus request is raised.
- R8: After the last byte, the block writes (pointer + count) mod 2^16 as a high byte to `PTR_ADDR` and a low byte to `PTR_ADDR+1`. It then writes `RECV_CODE` to `CMD_ADDR`, and `done_o` follows.
- R9: A raised bus request keeps its address, direction and write data unchanged until `bus_ack_i`. Each acknowledge completes exactly one access.
- R10: `done_o` is a one-cycle pulse. `count_o` keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a drain request (sampled while idle) |
| max_len_i | input | 16 | Largest byte count the requester accepts |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| count_o | output | 16 | Bytes moved by the last request |
| byte_valid_o | output | 1 | A received byte is offered |
| byte_data_o | output | 8 | Offered byte |
| byte_ready_i | input | 1 | Consumer accepts the offered byte |
| bus_req_o | output | 1 | Register access requested |
| bus_we_o | output | 1 | 1 = write access, 0 = read access |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_ack_i | input | 1 | Access completed this cycle |
| bus_rdata_i | input | 8 | Read data, valid with `bus_ack_i` |

## Verification
Most internal faults in this block show up at the register port, on the next access the block issues:
- A corrupted offset or run counter gives a wrong data address, or a missing jump back to the ring base, at the first fetch after the fault.
- A miscounted length shows up as an extra or missing fetch at the end of the data phase.
- The same miscount also gives a wrong pointer written back.

Faults in the stream handshake show up on the byte interface within a cycle, as a byte that changes while stalled or a fetch raised while a byte is still waiting.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_SZ_HI = 4'd1,
        ST_SZ_LO = 4'd2,
        ST_PT_HI = 4'd3,
        ST_PT_LO = 4'd4,
        ST_FETCH = 4'd5,
        ST_OFFER = 4'd6,
        ST_WB_HI = 4'd7,
        ST_WB_LO = 4'd8,
        ST_CMD   = 4'd9,
        ST_FIN   = 4'd10
    } rxd_state_e;

    typedef struct packed {
        rxd_state_e        st;
        logic [REG_W-1:0]  cap;       // request limit after the buffer clamp
        logic [BYTE_W-1:0] hi;        // high byte of a 16-bit register read
        logic [REG_W-1:0]  cnt;       // bytes this request will move
        logic [REG_W-1:0]  ptr;       // pointer as read, unmasked
        logic [REG_W-1:0]  run_left;  // bytes left in the current address run
        logic [REG_W-1:0]  remain;    // bytes left overall
        logic [REG_W-1:0]  addr;      // next data fetch address
        logic [BYTE_W-1:0] data;      // byte being offered
        logic [REG_W-1:0]  count;     // reported result
    } rxd_regs_t;

endpackage

// File: rtl/rxd_min.sv
module rxd_min #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] min_o
);
    always_comb begin
        min_o = (a_i < b_i) ? a_i : b_i;
    end
endmodule

// File: rtl/rxd_wrap_split.sv
module rxd_wrap_split
    import rxd_pkg::*;
#(
    parameter logic [REG_W-1:0] RING_BASE = 16'h6000,
    parameter logic [REG_W-1:0] RING_MASK = 16'h07FF
) (
    input  logic [REG_W-1:0] ptr_i,
    input  logic [REG_W-1:0] cnt_i,
    output logic [REG_W-1:0] start_o,
    output logic [REG_W-1:0] first_len_o
);
    localparam logic [REG_W:0] RING_SIZE = {1'b0, RING_MASK} + 1'b1;

    logic [REG_W:0] offset;
    logic [REG_W:0] room;
    logic [REG_W:0] span;

    always_comb begin
        offset      = {1'b0, ptr_i & RING_MASK};
        room        = RING_SIZE - offset;
        span        = offset + {1'b0, cnt_i};
        start_o     = RING_BASE + offset[REG_W-1:0];
        first_len_o = (span > RING_SIZE) ? room[REG_W-1:0] : cnt_i;
    end
endmodule

// File: rtl/rx_ring_drainer.sv
module rx_ring_drainer
    import rxd_pkg::*;
#(
    parameter logic [REG_W-1:0]  RING_BASE = 16'h6000,
    parameter logic [REG_W-1:0]  RING_MASK = 16'h07FF,
    parameter logic [REG_W-1:0]  BUF_LEN   = 16'd64,
    parameter logic [REG_W-1:0]  SIZE_ADDR = 16'h0426,
    parameter logic [REG_W-1:0]  PTR_ADDR  = 16'h0428,
    parameter logic [REG_W-1:0]  CMD_ADDR  = 16'h0401,
    parameter logic [BYTE_W-1:0] RECV_CODE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_W-1:0]  max_len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [REG_W-1:0]  count_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    input  logic              byte_ready_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [REG_W-1:0]  bus_addr_o,
    output logic [BYTE_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [BYTE_W-1:0] bus_rdata_i
);
    rxd_regs_t q, d;

    logic [REG_W-1:0] reg_word;    // high byte held, low byte arriving
    logic [REG_W-1:0] cap_now;
    logic [REG_W-1:0] take_now;
    logic [REG_W-1:0] start_addr;
    logic [REG_W-1:0] first_len;
    logic [REG_W-1:0] new_ptr;
    logic [REG_W-1:0] remain_dec;

    assign reg_word   = {q.hi, bus_rdata_i};
    assign new_ptr    = q.ptr + q.cnt;
    assign remain_dec = q.remain - 1'b1;

    // requester limit clamped to the local buffer
    rxd_min #(.W(REG_W)) u_cap_clamp (
        .a_i  (max_len_i),
        .b_i  (BUF_LEN),
        .min_o(cap_now)
    );

    // clamp again to what is waiting in the ring
    rxd_min #(.W(REG_W)) u_size_clamp (
        .a_i  (q.cap),
        .b_i  (reg_word),
        .min_o(take_now)
    );

    rxd_wrap_split #(
        .RING_BASE(RING_BASE),
        .RING_MASK(RING_MASK)
    ) u_split (
        .ptr_i      (reg_word),
        .cnt_i      (q.cnt),
        .start_o    (start_addr),
        .first_len_o(first_len)
    );

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.cap = cap_now;
                    d.st  = ST_SZ_HI;
                end
            end
            ST_SZ_HI: begin
                if (bus_ack_i) begin
                    d.hi = bus_rdata_i;
                    d.st = ST_SZ_LO;
                end
            end
            ST_SZ_LO: begin
                if (bus_ack_i) begin
                    if (reg_word == '0) begin
                        d.cnt   = '0;
                        d.count = '0;
                        d.st    = ST_FIN;
                    end else begin
                        d.cnt = take_now;
                        d.st  = ST_PT_HI;
                    end
                end
            end
            ST_PT_HI: begin
                if (bus_ack_i) begin
                    d.hi = bus_rdata_i;
                    d.st = ST_PT_LO;
                end
            end
            ST_PT_LO: begin
                if (bus_ack_i) begin
                    d.ptr      = reg_word;
                    d.addr     = start_addr;
                    d.run_left = first_len;
                    d.remain   = q.cnt;
                    d.st       = (q.cnt == '0) ? ST_WB_HI : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (bus_ack_i) begin
                    d.data = bus_rdata_i;
                    d.st   = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (byte_ready_i) begin
                    d.remain = remain_dec;
                    if (remain_dec == '0) begin
                        d.st = ST_WB_HI;
                    end else if (q.run_left == 16'd1) begin
                        // first run exhausted: continue at the ring base
                        d.addr     = RING_BASE;
                        d.run_left = remain_dec;
                        d.st       = ST_FETCH;
                    end else begin
                        d.addr     = q.addr + 1'b1;
                        d.run_left = q.run_left - 1'b1;
                        d.st       = ST_FETCH;
                    end
                end
            end
            ST_WB_HI: begin
                if (bus_ack_i) d.st = ST_WB_LO;
            end
            ST_WB_LO: begin
                if (bus_ack_i) d.st = ST_CMD;
            end
            ST_CMD: begin
                if (bus_ack_i) begin
                    d.count = q.cnt;
                    d.st    = ST_FIN;
                end
            end
            ST_FIN: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // port decode from registered state
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (q.st)
            ST_SZ_HI: begin bus_req_o = 1'b1; bus_addr_o = SIZE_ADDR; end
            ST_SZ_LO: begin bus_req_o = 1'b1; bus_addr_o = SIZE_ADDR + 1'b1; end
            ST_PT_HI: begin bus_req_o = 1'b1; bus_addr_o = PTR_ADDR; end
            ST_PT_LO: begin bus_req_o = 1'b1; bus_addr_o = PTR_ADDR + 1'b1; end
            ST_FETCH: begin bus_req_o = 1'b1; bus_addr_o = q.addr; end
            ST_WB_HI: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = PTR_ADDR;
                bus_wdata_o = new_ptr[REG_W-1:BYTE_W];
            end
            ST_WB_LO: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = PTR_ADDR + 1'b1;
                bus_wdata_o = new_ptr[BYTE_W-1:0];
            end
            ST_CMD: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = CMD_ADDR;
                bus_wdata_o = RECV_CODE;
            end
            default: ;
        endcase
    end

    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = (q.st == ST_FIN);
    assign count_o      = q.count;
    assign byte_valid_o = (q.st == ST_OFFER);
    assign byte_data_o  = q.data;

endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
    import rxd_pkg::*;
#(
    parameter logic [REG_W-1:0] RING_BASE = 16'h6000,
    parameter logic [REG_W-1:0] RING_MASK = 16'h07FF,
    parameter logic [REG_W-1:0] BUF_LEN   = 16'd64,
    parameter logic [REG_W-1:0] SIZE_ADDR = 16'h0426,
    parameter logic [REG_W-1:0] PTR_ADDR  = 16'h0428
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [REG_W-1:0]  count_o,
    input logic              byte_valid_o,
    input logic [BYTE_W-1:0] byte_data_o,
    input logic              byte_ready_i,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [REG_W-1:0]  bus_addr_o,
    input logic [BYTE_W-1:0] bus_wdata_o,
    input logic              bus_ack_i
);
    localparam logic [REG_W:0] WIN_TOP = {1'b0, RING_BASE} + {1'b0, RING_MASK};

    logic is_status_rd;
    assign is_status_rd = (bus_addr_o == SIZE_ADDR) || (bus_addr_o == SIZE_ADDR + 1'b1) ||
                          (bus_addr_o == PTR_ADDR)  || (bus_addr_o == PTR_ADDR + 1'b1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_data_o)); // R7

    AST_NO_FETCH_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> !bus_req_o); // R7

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> count_o <= BUF_LEN); // R3

    AST_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_we_o && !is_status_rd |->
            bus_addr_o >= RING_BASE && {1'b0, bus_addr_o} <= WIN_TOP); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(count_o)); // R10

endmodule

bind rx_ring_drainer rxd_checker #(
    .RING_BASE(RING_BASE),
    .RING_MASK(RING_MASK),
    .BUF_LEN  (BUF_LEN),
    .SIZE_ADDR(SIZE_ADDR),
    .PTR_ADDR (PTR_ADDR)
) u_rxd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .count_o     (count_o),
    .byte_valid_o(byte_valid_o),
    .byte_data_o (byte_data_o),
    .byte_ready_i(byte_ready_i),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
);

// File: tb/tb_rx_ring_drainer.sv
module tb_rx_ring_drainer;
    localparam int CLK_NS = 10;
    localparam logic [15:0] P_BASE = 16'h6000;
    localparam logic [15:0] P_MASK = 16'h07FF;
    localparam logic [15:0] P_BUF  = 16'd64;
    localparam logic [15:0] P_SIZE = 16'h0426;
    localparam logic [15:0] P_PTR  = 16'h0428;
    localparam logic [15:0] P_CMD  = 16'h0401;
    localparam logic [7:0]  P_RECV = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] max_len_i = '0;
    logic        busy_o, done_o, byte_valid_o, bus_req_o, bus_we_o;
    logic [15:0] count_o, bus_addr_o;
    logic [7:0]  byte_data_o, bus_wdata_o;
    logic        byte_ready_i = 1'b1;
    logic        bus_ack_i = 1'b0;
    logic [7:0]  bus_rdata_i = '0;

    always #(CLK_NS/2) clk = ~clk;

    rx_ring_drainer #(
        .RING_BASE(P_BASE), .RING_MASK(P_MASK), .BUF_LEN(P_BUF),
        .SIZE_ADDR(P_SIZE), .PTR_ADDR(P_PTR), .CMD_ADDR(P_CMD), .RECV_CODE(P_RECV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_len_i(max_len_i),
        .busy_o(busy_o), .done_o(done_o), .count_o(count_o),
        .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o), .byte_ready_i(byte_ready_i),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i)
    );

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } acc_t;

    acc_t        exp_acc[$];
    logic [7:0]  exp_byte[$];
    int          exp_count = 0;
    string       empty_tag = "R8";
    int          n_cmp = 0;
    int          n_bad = 0;

    // peripheral model state
    logic [15:0] cur_size = '0;
    logic [15:0] cur_ptr = '0;
    int          lat = 0;
    bit          stall_mode = 0;
    int          cyc = 0;
    bit          done_seen = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [7:0] ring_byte(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5C;
    endfunction

    function automatic logic [7:0] reg_read(input logic [15:0] a);
        if (a == P_SIZE)            return cur_size[15:8];
        if (a == P_SIZE + 16'd1)    return cur_size[7:0];
        if (a == P_PTR)             return cur_ptr[15:8];
        if (a == P_PTR + 16'd1)     return cur_ptr[7:0];
        return ring_byte(a);
    endfunction

    // peripheral responder, consumer and per-cycle comparison
    initial begin
        bit          hold_pend = 0;
        logic [15:0] hold_addr = '0;
        bit          stall_pend = 0;
        logic [7:0]  stall_byte = '0;
        int          wait_cnt = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                bus_ack_i = 1'b0;
                wait_cnt = 0;
            end else begin
                byte_ready_i = stall_mode ? (cyc % 3 != 0) : 1'b1;
                if (stall_pend) begin
                    chk(byte_valid_o && byte_data_o == stall_byte, "R7", "stalled byte held",
                        byte_data_o, stall_byte);
                    stall_pend = 0;
                end
                if (byte_valid_o) chk(!bus_req_o, "R7", "no access while byte waits", bus_req_o, 0);
                if (byte_valid_o && !byte_ready_i) begin
                    stall_pend = 1;
                    stall_byte = byte_data_o;
                end
                if (byte_valid_o && byte_ready_i) begin
                    if (exp_byte.size() == 0) chk(0, "R7", "unexpected byte", byte_data_o, 0);
                    else begin
                        logic [7:0] eb;
                        eb = exp_byte.pop_front();
                        chk(byte_data_o == eb, "R7", "stream byte", byte_data_o, eb);
                    end
                end
                if (hold_pend) begin
                    chk(bus_req_o && bus_addr_o == hold_addr, "R9", "request held until ack",
                        bus_addr_o, hold_addr);
                    hold_pend = 0;
                end
                if (bus_ack_i) begin
                    bus_ack_i = 1'b0;
                end else if (bus_req_o) begin
                    if (wait_cnt >= lat) begin
                        if (exp_acc.size() == 0) begin
                            chk(0, empty_tag, "access beyond expected sequence", bus_addr_o, 0);
                        end else begin
                            acc_t e;
                            e = exp_acc.pop_front();
                            chk(bus_we_o == e.we && bus_addr_o == e.a, e.tag, "access address/dir",
                                {bus_we_o, bus_addr_o}, {e.we, e.a});
                            if (e.we) chk(bus_wdata_o == e.d, e.tag, "write data", bus_wdata_o, e.d);
                        end
                        bus_rdata_i = bus_we_o ? 8'h00 : reg_read(bus_addr_o);
                        bus_ack_i = 1'b1;
                        wait_cnt = 0;
                    end else begin
                        wait_cnt++;
                        hold_pend = 1;
                        hold_addr = bus_addr_o;
                    end
                end
                if (done_o) begin
                    done_seen = 1;
                    chk(count_o == exp_count[15:0], (exp_count == 0 && cur_size == 0) ? "R4" : "R3",
                        "reported count", count_o, exp_count);
                    chk(exp_acc.size() == 0 && exp_byte.size() == 0, "R8",
                        "sequence complete at done", exp_acc.size() + exp_byte.size(), 0);
                end
            end
        end
    end

    task automatic run(input int mlen, input logic [15:0] size, input logic [15:0] ptr,
                       input int l, input bit stall);
        int n;
        logic [15:0] np;
        n = mlen;
        if (P_BUF < n) n = P_BUF;
        if (size < n)  n = size;
        cur_size = size;
        cur_ptr = ptr;
        lat = l;
        stall_mode = stall;
        empty_tag = (size == 0) ? "R4" : "R8";
        exp_acc.push_back('{0, P_SIZE, 8'h00, "R2"});
        exp_acc.push_back('{0, P_SIZE + 16'd1, 8'h00, "R2"});
        if (size == 0) begin
            exp_count = 0;
        end else begin
            exp_count = n;
            exp_acc.push_back('{0, P_PTR, 8'h00, "R2"});
            exp_acc.push_back('{0, P_PTR + 16'd1, 8'h00, "R2"});
            for (int i = 0; i < n; i++) begin
                int off;
                logic [15:0] a;
                off = int'(ptr & P_MASK) + i;
                if (off > int'(P_MASK)) off = off - (int'(P_MASK) + 1);
                a = P_BASE + off[15:0];
                exp_acc.push_back('{0, a, 8'h00, (int'(ptr & P_MASK) + i > int'(P_MASK)) ? "R6" : "R5"});
                exp_byte.push_back(ring_byte(a));
            end
            np = ptr + n[15:0];
            exp_acc.push_back('{1, P_PTR, np[15:8], "R8"});
            exp_acc.push_back('{1, P_PTR + 16'd1, np[7:0], "R8"});
            exp_acc.push_back('{1, P_CMD, P_RECV, "R8"});
        end
        done_seen = 0;
        @(negedge clk);
        max_len_i = mlen[15:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R10", "busy after start", busy_o, 1);
        while (!done_seen) @(negedge clk);
        @(negedge clk);
        chk(!done_o, "R10", "done is one cycle", done_o, 0);
        repeat (2) @(negedge clk);
        chk(count_o == exp_count[15:0], "R10", "count held after done", count_o, exp_count);
        chk(!busy_o, "R10", "idle after done", busy_o, 0);
        exp_acc.delete();
        exp_byte.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !bus_req_o && !byte_valid_o && count_o == 0, "R1",
            "reset state", {busy_o, done_o, bus_req_o, byte_valid_o, count_o}, 0);
        run(10, 16'd100, 16'h1234, 0, 0);   // plain run, no wrap (R5)
        run(20, 16'd50, 16'h37F8, 1, 1);    // wraps after 8 bytes, stalls (R6, R7)
        run(40, 16'd5, 16'hFFFE, 2, 0);     // size limits, pointer overflows 16 bits (R3, R8)
        run(200, 16'd300, 16'h0100, 0, 1);  // buffer limits to 64 (R3)
        run(10, 16'd0, 16'h0055, 1, 0);     // nothing waiting (R4)
        run(0, 16'd9, 16'h0222, 0, 0);      // zero request still commits pointer (R3, R8)
        run(16, 16'd16, 16'h07F0, 0, 1);    // ends exactly at ring top, no base read (R6)
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule